// File: doc/BRIEF.md
# PCI 64-bit Transfer Width Negotiator

This block sets the data width of each bus transaction for a PCI device that works both as initiator and as target. A pair of strap inputs is captured while reset is held. The value present at the last clock edge before reset is released enables or disables 64-bit operation until the next reset. When 64-bit operation is off, both sides run every transaction with 32-bit data phases.

On the initiator side the block raises the 64-bit request alongside FRAME. It does so only for commands and sizes that can use a wide path: no I/O cycles, no configuration cycles, and no transfers shorter than two dwords. It watches the target's DEVSEL cycle. If the target does not acknowledge the wide request, the block drops to 32-bit data phases for the rest of the transaction. In that case it splits each quadword beat from the datapath into a low half and a high half, and each half carries its own four byte enables. On the target side it acknowledges a wide request alongside DEVSEL, but only when the decoded hit lands in ordinary memory space.

Top module: `pci_width_neg`

## Requirements
- R1: `wide_mode_o` is 1 exactly when `strap_adr_i` and `strap_r64_i` were both 1 at the last rising clock edge while `rst_n` was low.
- R2: After `rst_n` goes high, changes on the strap inputs have no effect on `wide_mode_o` until the next reset.
- R3: From the cycle after a `m_start_i` pulse, `m_req64_o` is 1 exactly when wide mode is on, `m_cmd_i` is not an I/O command (4'b0010, 4'b0011) or configuration command (4'b1010, 4'b1011), and `m_len_dw_i` is at least 2.
- R4: `m_req64_o` and `m_wide_o` return to 0 in the cycle after a `m_end_i` pulse, and `m_req64_o` stays unchanged between start and end.
- R5: If `m_devsel_i` is 1 with `m_ack64_i` 0 while a request is active, `m_wide_o` is 0 from the next cycle until the next start. An acknowledged request keeps `m_wide_o` at 1.
- R6: `m_wide_o` is 1 exactly when the current transaction requested 64 bits and has not fallen back.
- R7: While `m_wide_o` is 0, a valid beat takes two cycles. The first presents `m_be_o` = {4'b0, be[3:0]} with `m_hi_half_o` 0 and `m_beat_ready_o` 0. The second presents {4'b0, be[7:4]} with `m_hi_half_o` 1 and `m_beat_ready_o` 1. A new start resets the split to the low half.
- R8: While `m_wide_o` is 1, a valid beat passes `m_be_o` = be unchanged, with `m_beat_ready_o` 1 and `m_hi_half_o` 0 in the same cycle.
- R9: `t_ack64_o` is 1 exactly when wide mode is on and `t_devsel_i` and `t_req64_i` are both 1 and `t_space_i` is 2'd0 (memory). The codes 2'd1 (configuration), 2'd2 (internal registers) and 2'd3 (reserved) never acknowledge.
- R10: With wide mode off, `m_req64_o` and `t_ack64_o` stay 0 for all inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; straps captured while low |
| strap_adr_i | input | 1 | Address-bus strap bit |
| strap_r64_i | input | 1 | REQ64 strap level (1 = asserted) |
| wide_mode_o | output | 1 | Captured 64-bit enable |
| m_start_i | input | 1 | Initiator asserts FRAME at this edge |
| m_end_i | input | 1 | Initiator deasserts FRAME at this edge |
| m_cmd_i | input | 4 | Bus command, valid with m_start_i |
| m_len_dw_i | input | 8 | Transfer size in dwords, valid with m_start_i |
| m_devsel_i | input | 1 | Target DEVSEL seen by initiator |
| m_ack64_i | input | 1 | Target ACK64 seen by initiator |
| m_req64_o | output | 1 | REQ64 drive (1 = asserted) |
| m_wide_o | output | 1 | Negotiated width: 1 = 64-bit phases |
| m_beat_valid_i | input | 1 | Datapath offers a quadword beat |
| m_beat_be_i | input | 8 | Byte enables of the beat |
| m_be_o | output | 8 | Byte enables of the current data phase |
| m_hi_half_o | output | 1 | Current 32-bit phase carries the high dword |
| m_beat_ready_o | output | 1 | Beat consumed at this edge |
| t_devsel_i | input | 1 | Target claims the transaction |
| t_req64_i | input | 1 | Initiator's REQ64 seen by target |
| t_space_i | input | 2 | Decoded hit: 0 memory, 1 config, 2 registers, 3 reserved |
| t_ack64_o | output | 1 | ACK64 drive (1 = asserted) |

## Verification
The initiator's fallback decision and the target's acknowledge decision can fall in the same cycle, because the device can be addressed by another initiator while its own transaction sees DEVSEL. The bench drives random target inputs in the exact cycle where the initiator sees DEVSEL with or without ACK64. It checks the combinational acknowledge in that cycle and the fallen-back width in the next. Both are judged against bench functions that restate the command filter and the region filter separately.

// File: rtl/pwn_pkg.sv
package pwn_pkg;
  typedef enum logic [1:0] {
    SP_MEM = 2'd0,
    SP_CFG = 2'd1,
    SP_REG = 2'd2,
    SP_RSV = 2'd3
  } space_e;

  // Commands that must never use a wide data path: I/O and configuration.
  function automatic logic narrow_only_cmd(input logic [3:0] cmd);
    return (cmd[3:1] == 3'b001) || (cmd[3:1] == 3'b101);
  endfunction

  function automatic logic wants_wide(input logic mode, input logic [3:0] cmd,
                                      input logic [31:0] len_dw);
    return mode && !narrow_only_cmd(cmd) && (len_dw >= 32'd2);
  endfunction

  function automatic logic region_allows_wide(input logic [1:0] sp);
    return sp == SP_MEM;
  endfunction
endpackage

// File: rtl/pwn_strap.sv
module pwn_strap (
  input  logic clk,
  input  logic rst_n,
  input  logic adr_i,
  input  logic r64_i,
  output logic wide_o
);
  logic wide_q;

  // Loads on every edge while reset is low; the last one before release wins.
  always_ff @(posedge clk) begin
    if (!rst_n) wide_q <= adr_i & r64_i;
  end

  assign wide_o = wide_q;
endmodule

// File: rtl/pwn_master.sv
module pwn_master #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic             start_i,
  input  logic             end_i,
  input  logic [3:0]       cmd_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             devsel_i,
  input  logic             ack64_i,
  output logic             req64_o,
  output logic             wide_o,
  output logic             fallback_hit_o
);
  import pwn_pkg::*;

  logic active_q, want_q, fb_q;

  assign fallback_hit_o = active_q && want_q && devsel_i && !ack64_i && !start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      want_q   <= 1'b0;
      fb_q     <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      want_q   <= wants_wide(mode_i, cmd_i, 32'(len_i));
      fb_q     <= 1'b0;
    end else if (end_i) begin
      active_q <= 1'b0;
      want_q   <= 1'b0;
      fb_q     <= 1'b0;
    end else if (fallback_hit_o) begin
      fb_q     <= 1'b1;
    end
  end

  assign req64_o = active_q && want_q;
  assign wide_o  = active_q && want_q && !fb_q;
endmodule

// File: rtl/pwn_lane_split.sv
module pwn_lane_split #(
  parameter int BE_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            wide_i,
  input  logic            valid_i,
  input  logic [BE_W-1:0] be_i,
  output logic [BE_W-1:0] be_o,
  output logic            hi_o,
  output logic            ready_o
);
  localparam int HALF = BE_W / 2;

  logic half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  half_q <= 1'b0;
    else if (clear_i)            half_q <= 1'b0;
    else if (valid_i && !wide_i) half_q <= ~half_q;
  end

  always_comb begin
    if (wide_i) begin
      be_o    = be_i;
      hi_o    = 1'b0;
      ready_o = valid_i;
    end else begin
      be_o    = '0;
      be_o[HALF-1:0] = half_q ? be_i[BE_W-1:HALF] : be_i[HALF-1:0];
      hi_o    = half_q;
      ready_o = valid_i && half_q;
    end
  end
endmodule

// File: rtl/pwn_target.sv
module pwn_target (
  input  logic       mode_i,
  input  logic       devsel_i,
  input  logic       req64_i,
  input  logic [1:0] space_i,
  output logic       ack64_o
);
  import pwn_pkg::*;

  assign ack64_o = mode_i && devsel_i && req64_i && region_allows_wide(space_i);
endmodule

// File: rtl/pci_width_neg.sv
module pci_width_neg #(
  parameter int LEN_W = 8,
  parameter int BE_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_adr_i,
  input  logic             strap_r64_i,
  output logic             wide_mode_o,
  input  logic             m_start_i,
  input  logic             m_end_i,
  input  logic [3:0]       m_cmd_i,
  input  logic [LEN_W-1:0] m_len_dw_i,
  input  logic             m_devsel_i,
  input  logic             m_ack64_i,
  output logic             m_req64_o,
  output logic             m_wide_o,
  input  logic             m_beat_valid_i,
  input  logic [BE_W-1:0]  m_beat_be_i,
  output logic [BE_W-1:0]  m_be_o,
  output logic             m_hi_half_o,
  output logic             m_beat_ready_o,
  input  logic             t_devsel_i,
  input  logic             t_req64_i,
  input  logic [1:0]       t_space_i,
  output logic             t_ack64_o
);
  logic mode;
  logic fallback_hit;

  pwn_strap u_strap (
    .clk   (clk),
    .rst_n (rst_n),
    .adr_i (strap_adr_i),
    .r64_i (strap_r64_i),
    .wide_o(mode)
  );

  pwn_master #(.LEN_W(LEN_W)) u_master (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode),
    .start_i       (m_start_i),
    .end_i         (m_end_i),
    .cmd_i         (m_cmd_i),
    .len_i         (m_len_dw_i),
    .devsel_i      (m_devsel_i),
    .ack64_i       (m_ack64_i),
    .req64_o       (m_req64_o),
    .wide_o        (m_wide_o),
    .fallback_hit_o(fallback_hit)
  );

  pwn_lane_split #(.BE_W(BE_W)) u_split (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear_i(m_start_i),
    .wide_i (m_wide_o),
    .valid_i(m_beat_valid_i),
    .be_i   (m_beat_be_i),
    .be_o   (m_be_o),
    .hi_o   (m_hi_half_o),
    .ready_o(m_beat_ready_o)
  );

  pwn_target u_target (
    .mode_i  (mode),
    .devsel_i(t_devsel_i),
    .req64_i (t_req64_i),
    .space_i (t_space_i),
    .ack64_o (t_ack64_o)
  );

  assign wide_mode_o = mode;
endmodule

// File: rtl/pwn_checker.sv
module pwn_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wide_mode_o,
  input logic       m_start_i,
  input logic       m_end_i,
  input logic       m_req64_o,
  input logic       m_wide_o,
  input logic       m_hi_half_o,
  input logic       m_beat_ready_o,
  input logic       t_devsel_i,
  input logic       t_req64_i,
  input logic [1:0] t_space_i,
  input logic       t_ack64_o,
  input logic       fallback_hit
);
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(wide_mode_o)); // R2
  AST_REQ_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    m_req64_o |-> wide_mode_o); // R10
  AST_REQ_RISES_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_req64_o) |-> $past(m_start_i)); // R3
  AST_REQ_DROPS_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    (m_end_i && !m_start_i) |=> !m_req64_o); // R4
  AST_FALLBACK_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (fallback_hit && !m_end_i) |=> (m_req64_o && !m_wide_o)); // R5
  AST_WIDE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    m_wide_o |-> m_req64_o); // R6
  AST_NARROW_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (m_beat_ready_o && !m_wide_o) |-> m_hi_half_o); // R7
  AST_ACK_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    t_ack64_o |-> (t_devsel_i && t_req64_i && t_space_i == 2'd0 && wide_mode_o)); // R9
endmodule

bind pci_width_neg pwn_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wide_mode_o   (wide_mode_o),
  .m_start_i     (m_start_i),
  .m_end_i       (m_end_i),
  .m_req64_o     (m_req64_o),
  .m_wide_o      (m_wide_o),
  .m_hi_half_o   (m_hi_half_o),
  .m_beat_ready_o(m_beat_ready_o),
  .t_devsel_i    (t_devsel_i),
  .t_req64_i     (t_req64_i),
  .t_space_i     (t_space_i),
  .t_ack64_o     (t_ack64_o),
  .fallback_hit  (fallback_hit)
);

// File: tb/pci_width_neg_bench.sv
module pci_width_neg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap_adr_i = 1'b0, strap_r64_i = 1'b0;
  logic       wide_mode_o;
  logic       m_start_i = 1'b0, m_end_i = 1'b0;
  logic [3:0] m_cmd_i = '0;
  logic [7:0] m_len_dw_i = '0;
  logic       m_devsel_i = 1'b0, m_ack64_i = 1'b0;
  logic       m_req64_o, m_wide_o;
  logic       m_beat_valid_i = 1'b0;
  logic [7:0] m_beat_be_i = '0;
  logic [7:0] m_be_o;
  logic       m_hi_half_o, m_beat_ready_o;
  logic       t_devsel_i = 1'b0, t_req64_i = 1'b0;
  logic [1:0] t_space_i = '0;
  logic       t_ack64_o;

  int checks = 0, fails = 0;
  logic mode_m = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pci_width_neg u_pci_width_neg (.*);

  function automatic logic exp_req(input logic md, input logic [3:0] c, input logic [7:0] n);
    logic io_or_cfg;
    io_or_cfg = (c == 4'h2) || (c == 4'h3) || (c == 4'hA) || (c == 4'hB);
    return md & ~io_or_cfg & (n > 8'd1);
  endfunction

  function automatic logic exp_ack(input logic md, input logic dv, input logic rq, input logic [1:0] sp);
    return md & dv & rq & (sp == 2'd0);
  endfunction

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, expv, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic a, input logic r);
    @(negedge clk);
    rst_n = 1'b0;
    strap_adr_i = ~a; strap_r64_i = ~r;
    step();
    strap_adr_i = a; strap_r64_i = r;
    step();
    rst_n = 1'b1;
    mode_m = a & r;
    #1 check("R1 strap capture", wide_mode_o, mode_m);
    check("R1 reset idle req", m_req64_o, 0);
    check("R1 reset idle wide", m_wide_o, 0);
    strap_adr_i = ~a; strap_r64_i = ~r;
    step();
    step();
    check("R2 strap ignored after reset", wide_mode_o, mode_m);
    strap_adr_i = 1'b1; strap_r64_i = 1'b1;
    step();
    check("R2 strap ignored after reset", wide_mode_o, mode_m);
  endtask

  task automatic drive_target(input logic dv, input logic rq, input logic [1:0] sp);
    t_devsel_i = dv; t_req64_i = rq; t_space_i = sp;
    #1 check(mode_m ? "R9 target ack" : "R10 target no ack", t_ack64_o, exp_ack(mode_m, dv, rq, sp));
  endtask

  task automatic txn(input logic [3:0] c, input logic [7:0] n, input logic ack, input int beats);
    logic rq, w;
    rq = exp_req(mode_m, c, n);
    m_start_i = 1'b1; m_cmd_i = c; m_len_dw_i = n;
    step();
    m_start_i = 1'b0;
    #1 check(mode_m ? "R3 req64 decision" : "R10 no req64", m_req64_o, rq);
    check("R6 width after start", m_wide_o, rq);
    step();
    check("R4 req64 steady", m_req64_o, rq);
    // DEVSEL cycle, with target side activity in the same cycle
    m_devsel_i = 1'b1; m_ack64_i = ack;
    drive_target($urandom % 2, $urandom % 2, 2'($urandom % 4));
    step();
    m_devsel_i = 1'b0; m_ack64_i = 1'b0;
    t_devsel_i = 1'b0;
    w = rq & ack;
    #1 check("R5 width after devsel", m_wide_o, w);
    check("R4 req64 steady", m_req64_o, rq);
    for (int b = 0; b < beats; b++) begin
      logic [7:0] be;
      be = 8'($urandom);
      m_beat_valid_i = 1'b1; m_beat_be_i = be;
      #1;
      if (w) begin
        check("R8 wide be", m_be_o, be);
        check("R8 wide ready", m_beat_ready_o, 1);
        check("R8 wide hi", m_hi_half_o, 0);
        step();
      end else begin
        check("R7 low half be", m_be_o, {4'b0, be[3:0]});
        check("R7 low half ready", m_beat_ready_o, 0);
        check("R7 low half hi", m_hi_half_o, 0);
        step();
        #1 check("R7 high half be", m_be_o, {4'b0, be[7:4]});
        check("R7 high half ready", m_beat_ready_o, 1);
        check("R7 high half hi", m_hi_half_o, 1);
        check("R5 width stays", m_wide_o, w);
        step();
      end
    end
    m_beat_valid_i = 1'b0;
    m_end_i = 1'b1;
    step();
    m_end_i = 1'b0;
    #1 check("R4 req64 drop", m_req64_o, 0);
    check("R4 width drop", m_wide_o, 0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED1);
    do_reset(1'b1, 1'b1);
    // directed corners
    txn(4'h7, 8'd2, 1'b1, 2);   // memory write, minimum wide size, acked
    txn(4'h6, 8'd8, 1'b0, 2);   // no ack -> fallback split
    txn(4'h7, 8'd1, 1'b1, 1);   // single dword, never wide
    txn(4'h2, 8'd4, 1'b1, 1);   // I/O
    txn(4'hB, 8'd4, 1'b1, 1);   // configuration
    for (int s = 0; s < 4; s++) drive_target(1'b1, 1'b1, 2'(s));
    drive_target(1'b0, 1'b1, 2'd0);
    drive_target(1'b1, 1'b0, 2'd0);
    for (int i = 0; i < 40; i++)
      txn(4'($urandom), 8'($urandom % 4), $urandom % 2, 1 + $urandom % 3);
    do_reset(1'b1, 1'b0);
    txn(4'h7, 8'd4, 1'b1, 1);
    for (int s = 0; s < 4; s++) drive_target(1'b1, 1'b1, 2'(s));
    do_reset(1'b0, 1'b1);
    for (int i = 0; i < 10; i++)
      txn(4'($urandom), 8'($urandom % 4), $urandom % 2, 1 + $urandom % 2);
    do_reset(1'b1, 1'b1);
    for (int i = 0; i < 30; i++)
      txn(4'($urandom), 8'($urandom % 6), $urandom % 2, 1 + $urandom % 3);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule